// File: doc/BRIEF.md
# Vectored Bus Interrupter with Selectable Release

This block raises a prioritised interrupt request on a backplane-style bus on behalf of an input-capture engine, and answers the host's interrupt-acknowledge cycle. The engine signals two kinds of cause. A change-of-state cause is raised by a capture event or by the event store reporting full. A marker cause comes from an encoder index. The block holds a pending flag for each cause. While the block is enabled and either flag is set, it asserts one request line for the programmed level (1 to 7).

During an acknowledge cycle, only the 3-bit level is meaningful. If the level matches and a request is up, the block drives the vector that belongs to the cause being served and asserts the data acknowledge until the strobe is released. Otherwise it passes the incoming daisy-chain grant downstream. When both causes are pending, the change-of-state cause is served first.

The release of the change-of-state request follows a software-selected policy. Under the first policy it drops when the acknowledge completes. Under the second it stays up until the event store reports empty.

Top module: `bus_interrupter`

## Requirements
- R1: With `cfg_int_en`=1, `cfg_level`=L in 1..7 and any cause pending, `irq` equals one-hot bit L-1 (bit 0 = level 1). With no cause pending or `cfg_level`=0, `irq` is all zero.
- R2: When `iack`, `ds` and `iackin` are high, `ack_level` equals `cfg_level` and a request is asserted, `dtack` goes high in the next cycle. It stays high while `ds` stays high and falls in the cycle after `ds` is seen low.
- R3: An acknowledge cycle at a non-matching level, or with no request asserted, never raises `dtack`. Instead `iackout` follows `iackin` from the next cycle until `ds` is seen low. With `iackin` low, neither `dtack` nor `iackout` is raised.
- R4: With `cfg_rofe`=0, the change-of-state request is withdrawn in the cycle after its acknowledge completes.
- R5: With `cfg_rofe`=1, the change-of-state request stays asserted after its acknowledge while `fifo_empty`=0, and later acknowledges are answered with the change-of-state vector again. It is withdrawn in the cycle after `fifo_empty` is seen high.
- R6: A `fifo_full` pulse raises the same request level and is answered with the same vector (`cfg_cos_vec`) as a `cos_event`.
- R7: The marker cause is answered with `cfg_mark_vec` and is cleared when its acknowledge completes, under either release policy.
- R8: With both causes pending, the first acknowledge returns `cfg_cos_vec` and the request stays up. The next acknowledge returns `cfg_mark_vec`.
- R9: `cfg_int_en`=0 forces `irq` to zero, and acknowledges are then passed on. Pending flags are kept, so setting the enable again restores the request.
- R10: `vec_out` is zero while `dtack` is low and does not change while `dtack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_level | input | 3 | Request level, 0 = none |
| cfg_int_en | input | 1 | Global request enable |
| cfg_rofe | input | 1 | 1 = hold change-of-state request until store empty |
| cfg_cos_vec | input | 8 | Vector for the change-of-state cause |
| cfg_mark_vec | input | 8 | Vector for the marker cause |
| cos_event | input | 1 | Change-of-state capture pulse |
| fifo_full | input | 1 | Event store full pulse |
| mark_event | input | 1 | Encoder marker pulse |
| fifo_empty | input | 1 | Event store empty flag |
| iack | input | 1 | Acknowledge cycle in progress |
| iackin | input | 1 | Daisy-chain grant in |
| ack_level | input | 3 | Level being acknowledged |
| ds | input | 1 | Data strobe, active high |
| irq | output | 7 | Request lines, bit k = level k+1 |
| iackout | output | 1 | Daisy-chain grant out |
| dtack | output | 1 | Data acknowledge |
| vec_out | output | 8 | Vector driven during acknowledge |

## Verification
The assertions assume that an acknowledge cycle keeps `iack`, `ack_level` and the configuration steady from the start of the strobe until `ds` falls. They also assume that `iackin` does not drop in the middle of a granted cycle. The stimulus changes configuration only between cycles, and it raises and lowers `ds` together with `iack` on the falling clock edge. Cause pulses are one cycle wide and are never issued while an acknowledge cycle is open.

// File: rtl/bus_interrupter.sv
module bus_interrupter #(
  parameter int LEVELS = 7,
  parameter int LVL_W  = 3,
  parameter int VEC_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic             cfg_int_en,
  input  logic             cfg_rofe,
  input  logic [VEC_W-1:0] cfg_cos_vec,
  input  logic [VEC_W-1:0] cfg_mark_vec,
  input  logic             cos_event,
  input  logic             fifo_full,
  input  logic             mark_event,
  input  logic             fifo_empty,
  input  logic             iack,
  input  logic             iackin,
  input  logic [LVL_W-1:0] ack_level,
  input  logic             ds,
  output logic [LEVELS-1:0] irq,
  output logic             iackout,
  output logic             dtack,
  output logic [VEC_W-1:0] vec_out
);

  typedef enum logic [1:0] {ST_IDLE, ST_RESP, ST_PASS} st_t;

  st_t              st;
  logic             cos_pend, cos_hold, mark_pend, serve_mark;
  logic [VEC_W-1:0] vec_q;

  wire pend  = cos_pend | cos_hold | mark_pend;
  wire req   = cfg_int_en && pend && (cfg_level != '0) && (int'(cfg_level) <= LEVELS);
  wire start = (st == ST_IDLE) && iack && ds && iackin;
  wire hit   = start && req && (ack_level == cfg_level);
  wire done  = (st == ST_RESP) && !ds;
  wire pick_mark = !cos_pend && mark_pend;

  for (genvar k = 0; k < LEVELS; k++) begin : g_irq
    assign irq[k] = req && (int'(cfg_level) == k + 1);
  end

  assign dtack   = (st == ST_RESP);
  assign iackout = (st == ST_PASS) && iackin;
  assign vec_out = dtack ? vec_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      serve_mark <= 1'b0;
      vec_q      <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st <= hit ? ST_RESP : ST_PASS;
          if (hit) begin
            serve_mark <= pick_mark;
            vec_q      <= pick_mark ? cfg_mark_vec : cfg_cos_vec;
          end
        end
        default: if (!ds) st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cos_pend  <= 1'b0;
      cos_hold  <= 1'b0;
      mark_pend <= 1'b0;
    end else begin
      if (cos_event || fifo_full)  cos_pend <= 1'b1;
      else if (done && !serve_mark) cos_pend <= 1'b0;

      if (fifo_empty)                             cos_hold <= 1'b0;
      else if (done && !serve_mark && cfg_rofe)   cos_hold <= 1'b1;

      if (mark_event)              mark_pend <= 1'b1;
      else if (done && serve_mark) mark_pend <= 1'b0;
    end
  end

  a_r1_single_level: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq));

  a_r3_grant_or_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !(dtack && iackout));

  a_r2_answer_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack) |-> $past(irq) != '0);

  a_r2_answer_level_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtack) |-> $past(ack_level) == $past(cfg_level));

  a_r2_release_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (dtack && !ds) |=> !dtack);

  a_r10_vector_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (dtack && $past(dtack)) |-> $stable(vec_out));

endmodule

// File: tb/bus_interrupter_tb.sv
module bus_interrupter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] VC = 8'hA5;
  localparam logic [7:0] VM = 8'h3C;

  logic clk = 0, rst_n = 0;
  logic [2:0] cfg_level = 3'd3, ack_level = 3'd0;
  logic cfg_int_en = 1, cfg_rofe = 0;
  logic [7:0] cfg_cos_vec = VC, cfg_mark_vec = VM;
  logic cos_event = 0, fifo_full = 0, mark_event = 0, fifo_empty = 0;
  logic iack = 0, iackin = 0, ds = 0;
  logic [6:0] irq;
  logic iackout, dtack;
  logic [7:0] vec_out;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic dtack_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_interrupter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_int_en(cfg_int_en),
    .cfg_rofe(cfg_rofe), .cfg_cos_vec(cfg_cos_vec), .cfg_mark_vec(cfg_mark_vec),
    .cos_event(cos_event), .fifo_full(fifo_full), .mark_event(mark_event),
    .fifo_empty(fifo_empty), .iack(iack), .iackin(iackin), .ack_level(ack_level),
    .ds(ds), .irq(irq), .iackout(iackout), .dtack(dtack), .vec_out(vec_out));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected vector on every new dtack
  always @(negedge clk) begin
    if (rst_n && dtack && !dtack_prev) begin
      if (exp_q.size() == 0) check("R2 unexpected answer", {24'd0, vec_out}, 32'hFFFF);
      else check("R2/R10 vector", {24'd0, vec_out}, {24'd0, exp_q.pop_front()});
    end
    if (rst_n && !dtack) check("R10 idle vector", {24'd0, vec_out}, 0);
    dtack_prev = dtack;
  end

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1;
    @(negedge clk) sig = 0;
  endtask

  task automatic do_ack(input logic [2:0] lvl, input bit answer, input logic [7:0] v,
                        input logic grant_in, input string req);
    if (answer) exp_q.push_back(v);
    @(negedge clk) begin iack = 1; ds = 1; iackin = grant_in; ack_level = lvl; end
    @(negedge clk);
    check({req, " dtack"}, dtack, answer);
    check({req, " iackout"}, iackout, !answer && grant_in);
    @(negedge clk);
    check({req, " dtack held"}, dtack, answer);
    ds = 0; iack = 0;
    @(negedge clk);
    check("R2 dtack drop", dtack, 0);
    check("R3 iackout drop", iackout, 0);
    iackin = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset irq", irq, 0);
    check("R2 reset dtack", dtack, 0);
    check("R3 reset iackout", iackout, 0);

    pulse(cos_event);
    check("R1 level3", irq, 7'b0000100);
    do_ack(3'd2, 0, 0, 1, "R3 other level");
    check("R3 still req", irq, 7'b0000100);
    do_ack(3'd3, 0, 0, 0, "R3 no grant in");
    do_ack(3'd3, 1, VC, 1, "R2 match");
    @(negedge clk);
    check("R4 roak release", irq, 0);
    do_ack(3'd3, 0, 0, 1, "R3 no request");

    pulse(fifo_full);
    check("R6 full req", irq, 7'b0000100);
    do_ack(3'd3, 1, VC, 1, "R6 full vec");
    check("R6 released", irq, 0);

    @(negedge clk) begin cos_event = 1; mark_event = 1; end
    @(negedge clk) begin cos_event = 0; mark_event = 0; end
    do_ack(3'd3, 1, VC, 1, "R8 cos first");
    check("R8 marker still", irq, 7'b0000100);
    do_ack(3'd3, 1, VM, 1, "R8 marker next");
    check("R7 marker cleared", irq, 0);

    cfg_int_en = 0;
    pulse(mark_event);
    check("R9 masked", irq, 0);
    do_ack(3'd3, 0, 0, 1, "R9 masked pass");
    cfg_int_en = 1;
    @(negedge clk);
    check("R9 restored", irq, 7'b0000100);
    do_ack(3'd3, 1, VM, 1, "R7 marker vec");
    check("R7 cleared", irq, 0);

    cfg_rofe = 1; fifo_empty = 0;
    pulse(cos_event);
    do_ack(3'd3, 1, VC, 1, "R5 first ack");
    @(negedge clk);
    check("R5 held", irq, 7'b0000100);
    do_ack(3'd3, 1, VC, 1, "R5 re-answer");
    check("R5 still held", irq, 7'b0000100);
    pulse(mark_event);
    do_ack(3'd3, 1, VM, 1, "R7 marker in rofe");
    check("R5 held after marker", irq, 7'b0000100);
    @(negedge clk) fifo_empty = 1;
    @(negedge clk);
    check("R5 released on empty", irq, 0);
    fifo_empty = 0; cfg_rofe = 0;

    cfg_level = 3'd0;
    pulse(cos_event);
    check("R1 level0", irq, 0);
    cfg_level = 3'd7;
    @(negedge clk);
    check("R1 level7", irq, 7'b1000000);
    do_ack(3'd7, 1, VC, 1, "R2 level7");
    check("R4 release l7", irq, 0);

    repeat (2) @(negedge clk);
    check("R2 queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule